// File: doc/BRIEF.md
# Power Fault and Enable Supervisor

This block decides, cycle by cycle, whether a power converter may switch, and it drives the power-good indication. It combines an enable pin whose active level is chosen by a static configuration input, an input-power-present flag, and four digital fault and status flags: overvoltage, overtemperature, overcurrent and light load. The analog comparators that produce these flags are outside the block; each flag arrives as a synchronous single-bit input.

Each fault class has its own recovery policy. An overvoltage trip latches the converter off until the module is disabled or loses input power and is then brought back. An overcurrent trip starts a fixed hiccup off-period, after which the converter retries by itself. An overtemperature condition holds the converter off only for as long as the flag is high. Power-good follows the run signal only after a programmable turn-on delay, and it also drops under light load while the converter keeps running.

Top module: `pwr_fault_supervisor`

## Requirements
- R1: The enable input is active high when `en_active_low` is 0 and active low when `en_active_low` is 1; the module counts as enabled only while the decoded enable level is 1 and `vin_ok` is 1.
- R2: `run` is 0 and `pgood` is 0 while `rst_n` is low; with no fault, `run` becomes 1 on the first clock edge at which the module is enabled and becomes 0 on the first edge at which it is not.
- R3: When `ov_flag` is 1 at an edge while the module is enabled, `run` is 0 after that edge and stays 0 after `ov_flag` returns to 0, for as long as the module stays enabled.
- R4: The overvoltage latch clears when the module is disabled at a clock edge, either through the enable input or by `vin_ok` going to 0; when the module is enabled again with `ov_flag` at 0, `run` returns to 1 on the first edge.
- R5: When `oc_flag` is 1 at an edge while `run` is 1, `run` is 0 for exactly HICCUP_CYCLES edges and then returns to 1 without outside action; `oc_flag` seen while `run` is 0 neither starts nor lengthens a hiccup period.
- R6: `run` is 0 on the edge after `ot_flag` is seen high and returns to 1 on the first edge at which `ot_flag` is seen low, with no latching.
- R7: `pgood` becomes 1 exactly DELAY_CYCLES edges after the edge at which `run` rises, provided `light_load` is 0; every restart of `run` restarts this delay.
- R8: `pgood` is 0 on the edge after `light_load` is seen high and returns to 1 on the edge after it is seen low once the delay has run out; `light_load` has no effect on `run`.
- R9: `pgood` is never 1 while `run` is 0, so it drops on disable, overvoltage, overtemperature and during a hiccup period.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| en_pin | input | 1 | Enable pin level |
| en_active_low | input | 1 | Static polarity select: 0 = high enables, 1 = low enables |
| vin_ok | input | 1 | Input power present |
| ov_flag | input | 1 | Output overvoltage comparator flag |
| ot_flag | input | 1 | Overtemperature comparator flag |
| oc_flag | input | 1 | Overcurrent comparator flag |
| light_load | input | 1 | Light-load comparator flag |
| run | output | 1 | Converter may switch |
| pgood | output | 1 | Power-good indication |

## Verification
On every cycle the assertions check the blocking rules: an armed overvoltage latch, a running hiccup timer or a seen overtemperature flag each force `run` low, loss of enable drops `run`, `pgood` never stands without `run` or before the delay count has filled, and light load always clears `pgood`. The exact lengths (the hiccup off-period, the turn-on delay and its restart after a retry) and the release paths of the latch need ordered stimulus, so only the bench's scenarios show them. The bench sweeps every combination of polarity, pin level and input power and then walks each fault's entry and recovery while counting edges.

// File: rtl/pfs_pkg.sv
package pfs_pkg;

  // Decoded enable level for a pin and a static polarity choice.
  function automatic logic en_level(input logic pin, input logic act_low);
    return act_low ? ~pin : pin;
  endfunction

  // Saturating increment used by the turn-on delay counter.
  function automatic logic [31:0] sat_next(input logic [31:0] cur, input logic [31:0] cap);
    return (cur >= cap) ? cap : cur + 32'd1;
  endfunction

  // Count-down step that stops at zero.
  function automatic logic [31:0] down_step(input logic [31:0] cur);
    return (cur == 32'd0) ? 32'd0 : cur - 32'd1;
  endfunction

endpackage

// File: rtl/pfs_enable_qual.sv
module pfs_enable_qual (
  input  logic en_pin,
  input  logic en_active_low,
  input  logic vin_ok,
  output logic active
);
  logic en_on;

  always_comb begin
    en_on  = pfs_pkg::en_level(en_pin, en_active_low);
    active = en_on & vin_ok;
  end
endmodule

// File: rtl/pfs_ov_latch.sv
module pfs_ov_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic active,
  input  logic ov_flag,
  output logic ov_next,
  output logic ov_q
);
  logic ov_trip;

  always_comb begin
    ov_trip = active & ov_flag;
    ov_next = active & (ov_q | ov_trip);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) ov_q <= 1'b0;
    else        ov_q <= ov_next;
  end

  // R3: once armed, the latch holds while the module stays enabled
  assert_ov_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (ov_q && active) |=> ov_q);

  // R4: disabling the module releases the latch
  assert_ov_release_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !active |=> !ov_q);
endmodule

// File: rtl/pfs_hiccup_timer.sv
module pfs_hiccup_timer #(
  parameter int unsigned HICCUP_CYCLES = 50000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic active,
  input  logic oc_flag,
  input  logic running,
  output logic busy_next,
  output logic busy_q
);
  localparam int HW = $clog2(HICCUP_CYCLES + 1);

  logic [HW-1:0] cnt_q;
  logic [HW-1:0] cnt_n;
  logic          hic_start;
  logic          hic_done;

  always_comb begin
    hic_start = active & oc_flag & running & (cnt_q == '0);
    hic_done  = (cnt_q == HW'(1));
    if (!active)        cnt_n = '0;
    else if (hic_start) cnt_n = HW'(HICCUP_CYCLES);
    else                cnt_n = HW'(pfs_pkg::down_step(32'(cnt_q)));
    busy_next = (cnt_n != '0);
    busy_q    = (cnt_q != '0);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_n;
  end

  // R5: every off-period starts from the full count
  assert_hic_load_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_q) |-> (cnt_q == HW'(HICCUP_CYCLES)));

  // R5: the last count ends the off-period unless power is withdrawn
  assert_hic_end_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (hic_done && active) |=> !busy_q);
endmodule

// File: rtl/pfs_turnon_delay.sv
module pfs_turnon_delay #(
  parameter int unsigned DELAY_CYCLES = 150000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run_next,
  output logic dly_done
);
  localparam int DW = $clog2(DELAY_CYCLES + 1);

  logic [DW-1:0] cnt_q;
  logic [DW-1:0] cnt_n;

  always_comb begin
    cnt_n    = run_next ? DW'(pfs_pkg::sat_next(32'(cnt_q), 32'(DELAY_CYCLES))) : '0;
    dly_done = (cnt_q == DW'(DELAY_CYCLES));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_n;
  end

  // R7: the count never passes its limit
  assert_dly_cap_R7: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= DW'(DELAY_CYCLES));
endmodule

// File: rtl/pwr_fault_supervisor.sv
module pwr_fault_supervisor #(
  parameter int unsigned DELAY_CYCLES  = 150000,
  parameter int unsigned HICCUP_CYCLES = 50000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en_pin,
  input  logic en_active_low,
  input  logic vin_ok,
  input  logic ov_flag,
  input  logic ot_flag,
  input  logic oc_flag,
  input  logic light_load,
  output logic run,
  output logic pgood
);
  logic active;
  logic ov_next, ov_lat;
  logic hic_busy_next, hic_busy;
  logic run_next, pg_next;
  logic dly_done;
  logic run_q, pg_q;

  pfs_enable_qual u_en (
    .en_pin        (en_pin),
    .en_active_low (en_active_low),
    .vin_ok        (vin_ok),
    .active        (active)
  );

  pfs_ov_latch u_ov (
    .clk     (clk),
    .rst_n   (rst_n),
    .active  (active),
    .ov_flag (ov_flag),
    .ov_next (ov_next),
    .ov_q    (ov_lat)
  );

  pfs_hiccup_timer #(.HICCUP_CYCLES(HICCUP_CYCLES)) u_hic (
    .clk       (clk),
    .rst_n     (rst_n),
    .active    (active),
    .oc_flag   (oc_flag),
    .running   (run_q),
    .busy_next (hic_busy_next),
    .busy_q    (hic_busy)
  );

  always_comb begin
    run_next = active & ~ov_next & ~ot_flag & ~hic_busy_next;
    pg_next  = run_next & ~light_load & dly_done;
  end

  pfs_turnon_delay #(.DELAY_CYCLES(DELAY_CYCLES)) u_dly (
    .clk      (clk),
    .rst_n    (rst_n),
    .run_next (run_next),
    .dly_done (dly_done)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run_q <= 1'b0;
      pg_q  <= 1'b0;
    end else begin
      run_q <= run_next;
      pg_q  <= pg_next;
    end
  end

  assign run   = run_q;
  assign pgood = pg_q;

  // R2: losing enable or input power stops the converter on the next edge
  assert_disable_stops_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !active |=> !run_q);

  // R3: an armed overvoltage latch keeps the converter off
  assert_ov_blocks_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ov_lat |-> !run_q);

  // R5: no switching during a hiccup off-period
  assert_hic_blocks_R5: assert property (@(posedge clk) disable iff (!rst_n)
    hic_busy |-> !run_q);

  // R6: overtemperature stops the converter on the next edge
  assert_ot_blocks_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ot_flag |=> !run_q);

  // R7: power-good only with a filled delay count
  assert_pg_delay_R7: assert property (@(posedge clk) disable iff (!rst_n)
    pg_q |-> dly_done);

  // R8: light load clears power-good on the next edge
  assert_ll_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
    light_load |=> !pg_q);

  // R9: power-good never without run
  assert_pg_needs_run_R9: assert property (@(posedge clk) disable iff (!rst_n)
    pg_q |-> run_q);
endmodule

// File: tb/pwr_fault_supervisor_tb.sv
module pwr_fault_supervisor_tb_top;
  localparam int unsigned D = 6;
  localparam int unsigned H = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic en_pin = 1'b0, en_active_low = 1'b0, vin_ok = 1'b0;
  logic ov_flag = 1'b0, ot_flag = 1'b0, oc_flag = 1'b0, light_load = 1'b0;
  logic run, pgood;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  always #4 clk = ~clk;  // 125 MHz

  pwr_fault_supervisor #(.DELAY_CYCLES(D), .HICCUP_CYCLES(H)) dut_i (
    .clk(clk), .rst_n(rst_n), .en_pin(en_pin), .en_active_low(en_active_low),
    .vin_ok(vin_ok), .ov_flag(ov_flag), .ot_flag(ot_flag), .oc_flag(oc_flag),
    .light_load(light_load), .run(run), .pgood(pgood)
  );

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string req, input logic act, input logic exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %0b expected %0b at %0t", req, act, exp, $time);
    end
  endtask

  // Enabled per R1: decoded pin level and input power both true.
  function automatic logic exp_active(input logic pin, input logic pol, input logic vin);
    return (pol ? !pin : pin) && vin;
  endfunction

  initial begin
    step(3);
    check("R2 reset run", run, 1'b0);
    check("R9 reset pgood", pgood, 1'b0);
    rst_n = 1'b1;

    // R1 sweep: every polarity, pin and power combination
    for (int pol = 0; pol < 2; pol++)
      for (int pin = 0; pin < 2; pin++)
        for (int vin = 0; vin < 2; vin++) begin
          en_active_low = pol[0]; en_pin = pin[0]; vin_ok = vin[0];
          step(D + 2);
          check("R1 run", run, exp_active(pin[0], pol[0], vin[0]));
          check("R1 pgood", pgood, exp_active(pin[0], pol[0], vin[0]));
        end

    // R2/R7: run on the first edge, pgood exactly D edges later
    en_active_low = 1'b0; vin_ok = 1'b1; en_pin = 1'b0;
    step(2);
    check("R2 disabled run", run, 1'b0);
    en_pin = 1'b1;
    step(1);
    check("R2 run after enable", run, 1'b1);
    for (int m = 1; m <= int'(D); m++) begin
      step(1);
      check("R7 turn-on delay", pgood, (m == int'(D)));
    end

    // R8: light load drops pgood only
    light_load = 1'b1;
    step(1);
    check("R8 pgood low", pgood, 1'b0);
    check("R8 run kept", run, 1'b1);
    light_load = 1'b0;
    step(1);
    check("R8 pgood back", pgood, 1'b1);

    // R3: overvoltage latches off
    ov_flag = 1'b1;
    step(1);
    check("R3 run off", run, 1'b0);
    check("R9 pgood off on ov", pgood, 1'b0);
    ov_flag = 1'b0;
    step(4);
    check("R3 latched", run, 1'b0);

    // R4: enable toggle releases the latch
    en_pin = 1'b0;
    step(1);
    en_pin = 1'b1;
    step(1);
    check("R4 release by enable", run, 1'b1);

    // R4: input power cycle releases the latch
    ov_flag = 1'b1;
    step(1);
    ov_flag = 1'b0;
    step(2);
    check("R3 latched again", run, 1'b0);
    vin_ok = 1'b0;
    step(1);
    vin_ok = 1'b1;
    step(1);
    check("R4 release by power", run, 1'b1);
    step(D + 1);
    check("R7 pgood after ov recovery", pgood, 1'b1);

    // R5: hiccup length, no extension, delay restart
    oc_flag = 1'b1;
    step(1);
    oc_flag = 1'b0;
    check("R5 hiccup starts", run, 1'b0);
    for (int m = 1; m <= int'(H); m++) begin
      if (m == 2) oc_flag = 1'b1;
      if (m == 3) oc_flag = 1'b0;
      step(1);
      check("R5 hiccup length", run, (m == int'(H)));
      check("R9 pgood during hiccup", pgood, 1'b0);
    end
    step(D - 1);
    check("R7 restart delay not done", pgood, 1'b0);
    step(1);
    check("R7 restart delay done", pgood, 1'b1);

    // R6: overtemperature is non-latching
    ot_flag = 1'b1;
    step(1);
    check("R6 run off", run, 1'b0);
    check("R9 pgood off on ot", pgood, 1'b0);
    step(3);
    check("R6 held while hot", run, 1'b0);
    ot_flag = 1'b0;
    step(1);
    check("R6 auto restart", run, 1'b1);

    // R1: active-low polarity with low pin runs, high pin stops
    en_active_low = 1'b1; en_pin = 1'b0;
    step(2);
    check("R1 active-low on", run, 1'b1);
    en_pin = 1'b1;
    step(1);
    check("R1 active-low off", run, 1'b0);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule